// File: doc/BRIEF.md
# Merging Write Buffer

This block posts writes on their way to a memory controller. A single write port takes one 32-bit DWORD per transfer: a DWORD address, four byte lanes of data and a four-bit lane enable. The requesters behind that port (a processor, a bus bridge and a DMA engine) are arbitrated upstream. A write carries one to four enabled lanes. DMA writes use at most two lanes. Bridge bursts may mix full and partial DWORDs. A drain port presents the oldest pending rank to memory with a valid/ready handshake.

The buffer holds `DEPTH` ranks, 32 by default. Together they hold eight lines of four DWORDs. A write whose address matches a pending rank that is not currently on the drain port is merged into that rank and does not take a new slot. Every other write takes the next free rank in arrival order. Each merge produces a one-cycle hit pulse. Each cycle in which a write is refused because the buffer is full produces a one-cycle full pulse. A performance monitor counts both pulses. `DEPTH` must be a power of two.

Top module: `wmerge_buf`

## Requirements
- R1: While reset is held and for the cycles after it is released, `dr_valid`, `hit_pulse` and `full_pulse` are low and `wr_ready` is high.
- R2: Writes that do not merge leave on the drain port in arrival order, each with the address, data and lane enables it was written with.
- R3: A write that matches a pending rank other than the one on the drain port is merged into that rank. Only its enabled lanes (bit k of `wr_be` covers `wr_data[8k+7:8k]`) are overwritten, so the later write wins on overlapping lanes. The rank's lane enables become the OR of both enables. No new rank is used.
- R4: `hit_pulse` is high for exactly the one cycle after each accepted merging write, and low otherwise.
- R5: The rank presented on the drain port is never a merge target. A write to its address takes a new rank, and `dr_addr`, `dr_data` and `dr_be` stay unchanged while `dr_valid` is high and `dr_ready` is low.
- R6: With all `DEPTH` ranks occupied, a write that does not merge sees `wr_ready` low and is not taken. `full_pulse` is high in the cycle after each such refused cycle. With fewer than `DEPTH` ranks occupied, `wr_ready` is high.
- R7: With the buffer full, a write that merges into a non-head rank is still accepted.
- R8: A write and a drain transfer in the same cycle are both carried out, and the order of the remaining ranks is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | A write is offered |
| wr_ready | output | 1 | The offered write is taken at this edge |
| wr_addr | input | ADDR_W | DWORD address of the write |
| wr_data | input | 32 | Write data, four byte lanes |
| wr_be | input | 4 | Lane enables, bit k for byte lane k |
| dr_valid | output | 1 | A pending rank is presented |
| dr_ready | input | 1 | Memory takes the presented rank |
| dr_addr | output | ADDR_W | DWORD address of the oldest rank |
| dr_data | output | 32 | Data of the oldest rank |
| dr_be | output | 4 | Accumulated lane enables of the oldest rank |
| hit_pulse | output | 1 | One-cycle pulse per merged write |
| full_pulse | output | 1 | One-cycle pulse per write refused for lack of space |

## Verification
The assertions assume that `wr_be` is never zero on an offered write and that address, data and enables are held steady while `wr_valid` is high. The bench drives each write for a single cycle, always with at least one enabled lane. It keeps `dr_ready` low whenever a write could match a pending rank. That way the head of its expected queue is always the rank on the drain port when a merge is decided. The same-cycle write-and-drain case is driven only with fresh addresses that cannot merge.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;

  // overwrite only the enabled byte lanes of old_w with new_w
  function automatic word_t lane_merge(word_t old_w, word_t new_w, lane_t en);
    word_t res;
    res = old_w;
    for (int b = 0; b < int'(LANES); b++) begin
      if (en[b]) res[b*LANE_W +: LANE_W] = new_w[b*LANE_W +: LANE_W];
    end
    return res;
  endfunction
endpackage

// File: rtl/wmb_rst_sync.sv
module wmb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/wmb_ctrl.sv
module wmb_ctrl #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] count_d;
  logic             upd_en;

  always_comb begin
    upd_en  = push | pop;
    head_d  = head + (pop ? PTR_W'(1) : PTR_W'(0));
    tail_d  = tail + (push ? PTR_W'(1) : PTR_W'(0));
    count_d = count + (push ? CNT_W'(1) : CNT_W'(0)) - (pop ? CNT_W'(1) : CNT_W'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (upd_en) begin
      head  <= head_d;
      tail  <= tail_d;
      count <= count_d;
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/wmb_match.sv
module wmb_match #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned PTR_W  = $clog2(DEPTH),
  parameter int unsigned CNT_W  = PTR_W + 1
) (
  input  logic [ADDR_W-1:0] tags [DEPTH],
  input  logic [PTR_W-1:0]  head,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] probe,
  output logic [DEPTH-1:0]  match_vec,
  output logic              hit,
  output logic [PTR_W-1:0]  hit_idx
);
  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_rank
    logic [PTR_W-1:0] age;
    logic             live;
    // distance from head; the head rank itself (age 0) is excluded
    assign age          = PTR_W'(i) - head;
    assign live         = (age != '0) && ({1'b0, age} < count);
    assign match_vec[i] = live && (tags[i] == probe);
  end

  assign hit = |match_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = PTR_W'(i);
    end
  end
endmodule

// File: rtl/wmerge_buf.sv
module wmerge_buf
  import wmb_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  output logic              dr_valid,
  input  logic              dr_ready,
  output logic [ADDR_W-1:0] dr_addr,
  output logic [31:0]       dr_data,
  output logic [3:0]        dr_be,
  output logic              hit_pulse,
  output logic              full_pulse
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic              rst_q_n;
  logic [PTR_W-1:0]  head, tail, hit_idx;
  logic [CNT_W-1:0]  count;
  logic              full, empty, hit;
  logic [DEPTH-1:0]  match_vec;
  logic              accept, merge_en, alloc_en, pop;
  logic              hit_d, full_d;

  logic [ADDR_W-1:0] tag_arr  [DEPTH];
  word_t             data_arr [DEPTH];
  lane_t             en_arr   [DEPTH];

  wmb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  wmb_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_q_n),
    .push  (alloc_en),
    .pop   (pop),
    .head  (head),
    .tail  (tail),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  wmb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_match (
    .tags      (tag_arr),
    .head      (head),
    .count     (count),
    .probe     (wr_addr),
    .match_vec (match_vec),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  // write side handshake
  assign wr_ready = hit | ~full;
  assign accept   = wr_valid & wr_ready;
  assign merge_en = accept & hit;
  assign alloc_en = accept & ~hit;

  // drain side
  assign dr_valid = ~empty;
  assign pop      = dr_valid & dr_ready;
  assign dr_addr  = tag_arr[head];
  assign dr_data  = data_arr[head];
  assign dr_be    = en_arr[head];

  // rank storage, no reset on the data path
  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_store
    logic [ADDR_W-1:0] tag_r;
    word_t             data_r, data_n;
    lane_t             en_r, en_n;
    logic              sel_alloc, sel_merge, st_en;

    always_comb begin
      sel_alloc = alloc_en && (tail == PTR_W'(i));
      sel_merge = merge_en && (hit_idx == PTR_W'(i));
      st_en     = sel_alloc | sel_merge;
      if (sel_alloc) begin
        data_n = wr_data;
        en_n   = wr_be;
      end else begin
        data_n = lane_merge(data_r, wr_data, wr_be);
        en_n   = en_r | wr_be;
      end
    end

    always_ff @(posedge clk) begin
      if (st_en) begin
        data_r <= data_n;
        en_r   <= en_n;
      end
      if (sel_alloc) tag_r <= wr_addr;
    end

    assign tag_arr[i]  = tag_r;
    assign data_arr[i] = data_r;
    assign en_arr[i]   = en_r;
  end

  // monitor pulses
  always_comb begin
    hit_d  = merge_en;
    full_d = wr_valid & ~wr_ready;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      hit_pulse  <= 1'b0;
      full_pulse <= 1'b0;
    end else begin
      hit_pulse  <= hit_d;
      full_pulse <= full_d;
    end
  end
endmodule

// File: rtl/wmb_chk.sv
module wmb_chk #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned CNT_W  = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              dr_valid,
  input logic              dr_ready,
  input logic [ADDR_W-1:0] dr_addr,
  input logic [31:0]       dr_data,
  input logic [3:0]        dr_be,
  input logic              hit_pulse,
  input logic              full_pulse,
  input logic [CNT_W-1:0]  count,
  input logic [DEPTH-1:0]  match_vec
);
  // at most one non-head rank can hold a given address
  assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(match_vec));

  // a hit pulse follows only an accepted write
  assert_hit_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    hit_pulse |-> $past(wr_valid && wr_ready));

  assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(hit_pulse && full_pulse));

  // the presented rank does not change under a merge while stalled
  assert_head_stable_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dr_valid && !dr_ready) |=> ($stable(dr_addr) && $stable(dr_data) && $stable(dr_be)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    count <= CNT_W'(DEPTH));

  assert_ready_with_room_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (count < CNT_W'(DEPTH)) |-> wr_ready);

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !rst_q_n |=> (!hit_pulse && !full_pulse));
endmodule

bind wmerge_buf wmb_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .dr_valid   (dr_valid),
  .dr_ready   (dr_ready),
  .dr_addr    (dr_addr),
  .dr_data    (dr_data),
  .dr_be      (dr_be),
  .hit_pulse  (hit_pulse),
  .full_pulse (full_pulse),
  .count      (count),
  .match_vec  (match_vec)
);

// File: tb/wmerge_buf_tb_top.sv
`timescale 1ns/1ps
module wmerge_buf_tb_top;
  localparam int DEPTH  = 32;
  localparam int ADDR_W = 30;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [31:0]       d;
    logic [3:0]        e;
  } ent_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [3:0]        wr_be = '0;
  logic              dr_valid;
  logic              dr_ready = 1'b0;
  logic [ADDR_W-1:0] dr_addr;
  logic [31:0]       dr_data;
  logic [3:0]        dr_be;
  logic              hit_pulse, full_pulse;

  int   checks = 0;
  int   failures = 0;
  bit   mon_on = 0;
  bit   done = 0;
  ent_t exp_q[$];

  always #5 clk = ~clk;

  wmerge_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_be(dr_be),
    .hit_pulse(hit_pulse), .full_pulse(full_pulse)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every drain transfer against the expected queue
  always @(negedge clk) begin
    if (mon_on) begin
      check(dr_valid === (exp_q.size() != 0), "R2", "dr_valid", 64'(dr_valid), 64'(exp_q.size() != 0));
      if (dr_valid && dr_ready && exp_q.size() != 0) begin
        ent_t x;
        x = exp_q.pop_front();
        check(dr_addr === x.a, "R2", "dr_addr", 64'(dr_addr), 64'(x.a));
        check(dr_data === x.d, "R3", "dr_data", 64'(dr_data), 64'(x.d));
        check(dr_be === x.e, "R3", "dr_be", 64'(dr_be), 64'(x.e));
      end
    end
  end

  // expected merge target: a queued entry other than the head one
  function automatic int find_target(logic [ADDR_W-1:0] a);
    for (int i = 1; i < exp_q.size(); i++) begin
      if (exp_q[i].a == a) return i;
    end
    return -1;
  endfunction

  task automatic do_write(logic [ADDR_W-1:0] a, logic [31:0] d, logic [3:0] e, string req);
    int  tgt;
    bit  exp_rdy;
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = e;
    @(negedge clk);
    tgt     = find_target(a);
    exp_rdy = (tgt >= 0) || (exp_q.size() < DEPTH);
    check(wr_ready === exp_rdy, req, "wr_ready", 64'(wr_ready), 64'(exp_rdy));
    @(posedge clk); #1;
    wr_valid = 1'b0;
    if (exp_rdy) begin
      if (tgt >= 0) begin
        for (int b = 0; b < 4; b++) begin
          if (e[b]) exp_q[tgt].d[b*8 +: 8] = d[b*8 +: 8];
        end
        exp_q[tgt].e = exp_q[tgt].e | e;
      end else begin
        ent_t n;
        n.a = a; n.d = d; n.e = e;
        exp_q.push_back(n);
      end
    end
    @(negedge clk);
    check(hit_pulse === (exp_rdy && tgt >= 0), "R4", "hit_pulse", 64'(hit_pulse), 64'(exp_rdy && tgt >= 0));
    check(full_pulse === !exp_rdy, "R6", "full_pulse", 64'(full_pulse), 64'(!exp_rdy));
  endtask

  task automatic drain_all();
    @(posedge clk); #1;
    dr_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
    dr_ready = 1'b0;
    @(negedge clk);
    check(dr_valid === 1'b0, "R2", "empty after drain", 64'(dr_valid), 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dr_valid === 1'b0, "R1", "dr_valid in reset", 64'(dr_valid), 64'd0);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(dr_valid === 1'b0, "R1", "dr_valid", 64'(dr_valid), 64'd0);
    check(wr_ready === 1'b1, "R1", "wr_ready", 64'(wr_ready), 64'd1);
    check(hit_pulse === 1'b0 && full_pulse === 1'b0, "R1", "pulses", 64'({hit_pulse, full_pulse}), 64'd0);
    mon_on = 1;

    // R2: plain FIFO order, full and partial writes
    do_write(30'h10, 32'h1111_1111, 4'hF, "R2");
    do_write(30'h20, 32'h0000_22AA, 4'h3, "R2");
    do_write(30'h30, 32'h3300_0000, 4'h8, "R2");
    drain_all();

    // R3 R5: merges behind the head, head address takes a new rank
    do_write(30'h100, 32'hA0A1_A2A3, 4'hF, "R3");
    do_write(30'h200, 32'h0000_AABB, 4'h3, "R3");
    do_write(30'h200, 32'h00CC_DD00, 4'h6, "R3");
    do_write(30'h100, 32'h5500_0000, 4'h8, "R5");
    do_write(30'h100, 32'h0000_0066, 4'h1, "R5");
    do_write(30'h300, 32'h0000_7700, 4'h2, "R3");
    do_write(30'h300, 32'h8800_0000, 4'h8, "R3");
    drain_all();

    // R6 R7: fill every rank, refuse a new address, still merge
    for (int i = 0; i < DEPTH; i++)
      do_write(30'h1000 + 30'(i), 32'(i) * 32'h0101_0101, 4'hF, "R6");
    do_write(30'h1000 + 30'(DEPTH), 32'hDEAD_BEEF, 4'hF, "R6");
    do_write(30'h1005, 32'hEE00_0000, 4'h8, "R7");
    do_write(30'h1000, 32'h0000_0099, 4'h1, "R6");
    drain_all();

    // R8: writes with fresh addresses while the drain runs
    do_write(30'h400, 32'h4444_4444, 4'hF, "R8");
    do_write(30'h401, 32'h0000_4545, 4'h3, "R8");
    do_write(30'h402, 32'h4600_0000, 4'h8, "R8");
    @(posedge clk); #1;
    dr_ready = 1'b1;
    do_write(30'h403, 32'h4747_4747, 4'hF, "R8");
    do_write(30'h404, 32'h0048_0000, 4'h4, "R8");
    drain_all();

    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule